// File: doc/BRIEF.md
# Nonvolatile Data Byte Store Controller

This block sits on a CPU register bus and controls a small byte-wide nonvolatile data store, modelled here as a 256 x 8 register array. Software loads a byte address and a data byte through bus registers. It then starts a read by setting a read-start bit, and the byte is fetched into the data register on the next cycle. To write, software sets a write-enable bit and feeds the two unlock values to a keyhole register. On the very next bus access it sets a write-start bit. The controller then runs a self-timed write of a parameterised number of cycles.

While the timed write runs, the control, address and data registers are locked. When the write finishes, the write-start bit clears and a sticky completion flag is raised toward the interrupt controller. A reset of the rest of the chip that arrives during the write aborts the write and sets an error bit. The select bits are preserved so software can see what was under way. A power-up-timer input blocks any write from starting.

Register select codes: 0 control, 1 address, 2 data, 3 unlock keyhole, 4 completion flag. Control bits: 7 program-store select, 6 configuration select, 5 always 0, 4 erase select, 3 error, 2 write enable, 1 write start / busy, 0 read start.

Top module: `nvm_byte_ctrl`

## Requirements
- R1: After rst_n low, the control, address, data, keyhole and flag registers all read 0x00. Bit 5 of the control register always reads 0, even after 1 is written to it.
- R2: Writing the control register with bit 0 = 1 and bit 7 = 0 sets bit 0 for one cycle only. On the following clock edge the data register takes the array byte at the current address and bit 0 returns to 0.
- R3: A control write with bit 0 = 1 and bit 7 = 1 starts no read, and the data register keeps its value.
- R4: A write starts only after three consecutive bus writes: the keyhole gets 0x55, the keyhole gets 0xAA, then the control register gets bit 1 = 1. Any other bus write in between cancels the sequence, and the keyhole always reads 0x00.
- R5: Bit 1 is ignored unless write enable (bit 2) was already 1 before that bus write. Setting bits 1 and 2 in the same write sets only bit 2.
- R6: A started write keeps bit 1 reading 1 for exactly WRITE_CYCLES cycles. It then stores the data byte at the address, clears bit 1, sets the completion flag and leaves write enable at 1.
- R7: The completion flag (register 4, bit 0) is cleared only by a bus write of bit 0 = 0, and writing 1 has no effect. If the clear falls on the completion edge, the flag ends up set.
- R8: While bit 1 reads 1, bus writes to the control, address and data registers are ignored.
- R9: When core_rst_hit is high during a write, the write is dropped and the array is unchanged. Bit 3 becomes 1, bit 1, bit 2 and bit 0 clear, bits 7, 6 and 4 keep their values, address and data become 0x00, and no completion flag is raised.
- R10: While pwrt_active is high, no write can start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| bus_addr | input | 3 | Register select |
| bus_we | input | 1 | Bus write strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| core_rst_hit | input | 1 | Chip reset seen by the block; aborts a running write |
| pwrt_active | input | 1 | Power-up timer running; blocks write start |
| wdone_irq | output | 1 | Sticky write-complete flag |

## Verification
Two pairs of events can land on the same clock edge. The first is the end of a timed write and a software clear of the completion flag. The bench counts WRITE_CYCLES from the starting bus write and places a flag-clear write on exactly the completion edge. The flag must read 1 afterwards, and a later clear must still work. The second is a core reset that overlaps the running write. It is judged by the error bit, the kept select and erase bits, the missing flag, and the old array byte read back afterwards.

// File: rtl/nvm_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the data byte store controller.
// Assumes an 8-bit control register layout; bit positions are fixed by software.
package nvm_pkg;
    localparam int REG_SEL_W = 3;

    localparam logic [REG_SEL_W-1:0] SEL_CTRL = 3'd0;
    localparam logic [REG_SEL_W-1:0] SEL_ADDR = 3'd1;
    localparam logic [REG_SEL_W-1:0] SEL_DATA = 3'd2;
    localparam logic [REG_SEL_W-1:0] SEL_KEY  = 3'd3;
    localparam logic [REG_SEL_W-1:0] SEL_FLAG = 3'd4;

    localparam int B_PGM   = 7;
    localparam int B_CFG   = 6;
    localparam int B_ERASE = 4;
    localparam int B_ERR   = 3;
    localparam int B_WEN   = 2;
    localparam int B_WGO   = 1;
    localparam int B_RGO   = 0;

    typedef enum logic [1:0] {
        KEY_IDLE  = 2'd0,
        KEY_HALF  = 2'd1,
        KEY_ARMED = 2'd2
    } key_state_t;
endpackage

// File: rtl/nvm_unlock_fsm.sv
`timescale 1ns/1ps
// Unlock tracker: follows consecutive bus writes and reports "armed" once the
// keyhole has received KEY1 then KEY2 with no other bus write in between.
// Assumes every bus write is one cycle of bus_we; flush forces idle.
module nvm_unlock_fsm
    import nvm_pkg::*;
#(
    parameter int               DATA_W = 8,
    parameter logic [DATA_W-1:0] KEY1  = 8'h55,
    parameter logic [DATA_W-1:0] KEY2  = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              bus_we,
    input  logic              key_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic              armed
);
    key_state_t state_q;

    // Advance on the expected key, fall back to idle on anything else.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            state_q <= KEY_IDLE;
        end else if (bus_we) begin
            case (state_q)
                KEY_IDLE:  state_q <= (key_sel && wdata == KEY1) ? KEY_HALF  : KEY_IDLE;
                KEY_HALF:  state_q <= (key_sel && wdata == KEY2) ? KEY_ARMED : KEY_IDLE;
                default:   state_q <= KEY_IDLE;
            endcase
        end
    end

    assign armed = (state_q == KEY_ARMED);
endmodule

// File: rtl/nvm_write_timer.sv
`timescale 1ns/1ps
// Self-timed write sequencer: busy for exactly WRITE_CYCLES cycles after start,
// then a one-cycle done pulse. Abort drops busy with no done pulse.
// Assumes start is only raised while not busy; WRITE_CYCLES >= 1.
module nvm_write_timer #(
    parameter int WRITE_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Completion fires on the last counted cycle unless aborted.
    assign done = busy && (cnt_q == CNT_W'(1)) && !abort;

    // Load, count down and retire the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (abort) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= CNT_W'(WRITE_CYCLES);
        end else if (busy) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/nvm_store.sv
`timescale 1ns/1ps
// Byte array standing in for the nonvolatile cells: one write port, one
// combinational read port. Contents are not reset (nonvolatile model).
module nvm_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Commit a byte at the end of a timed write.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/nvm_byte_ctrl.sv
`timescale 1ns/1ps
// Data byte store controller: bus-visible control, address, data, keyhole and
// completion-flag registers around an unlock tracker, a write timer and the
// byte array. Assumes ADDR_W <= DATA_W and DATA_W >= 8. rst_n is power-up,
// core_rst_hit is a later chip reset that only aborts and partly clears.
module nvm_byte_ctrl
    import nvm_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 8,
    parameter int WRITE_CYCLES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_SEL_W-1:0] bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 core_rst_hit,
    input  logic                 pwrt_active,
    output logic                 wdone_irq
);
    // Control fields.
    logic pgm_q, cfg_q, erase_q, err_q, wen_q, rgo_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              irq_q;

    logic busy, done, armed;
    logic [DATA_W-1:0] cell_rd;

    // Decoded, lock-qualified bus writes.
    logic ctrl_wr, addr_wr, data_wr, flag_wr, key_sel;
    logic start_wr, start_rd;

    assign key_sel  = (bus_addr == SEL_KEY);
    assign ctrl_wr  = bus_we && (bus_addr == SEL_CTRL) && !busy && !core_rst_hit;
    assign addr_wr  = bus_we && (bus_addr == SEL_ADDR) && !busy && !core_rst_hit;
    assign data_wr  = bus_we && (bus_addr == SEL_DATA) && !busy && !core_rst_hit;
    assign flag_wr  = bus_we && (bus_addr == SEL_FLAG);

    // Write needs enable from an earlier write, an armed tracker and no power-up hold.
    assign start_wr = ctrl_wr && bus_wdata[B_WGO] && wen_q && armed && !pwrt_active;
    // Read needs the program-store select clear in the value written; a write start wins.
    assign start_rd = ctrl_wr && bus_wdata[B_RGO] && !bus_wdata[B_PGM] && !start_wr;

    nvm_unlock_fsm #(
        .DATA_W (DATA_W),
        .KEY1   (DATA_W'(8'h55)),
        .KEY2   (DATA_W'(8'hAA))
    ) u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (busy || core_rst_hit),
        .bus_we  (bus_we),
        .key_sel (key_sel),
        .wdata   (bus_wdata),
        .armed   (armed)
    );

    nvm_write_timer #(
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_wr),
        .abort (core_rst_hit),
        .busy  (busy),
        .done  (done)
    );

    nvm_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk   (clk),
        .we    (done),
        .waddr (addr_q),
        .wdata (data_q),
        .raddr (addr_q),
        .rdata (cell_rd)
    );

    // Control register: plain fields, set-only read start, abort bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pgm_q   <= 1'b0;
            cfg_q   <= 1'b0;
            erase_q <= 1'b0;
            err_q   <= 1'b0;
            wen_q   <= 1'b0;
            rgo_q   <= 1'b0;
        end else if (core_rst_hit) begin
            wen_q <= 1'b0;
            rgo_q <= 1'b0;
            if (busy) begin
                err_q <= 1'b1;
            end
        end else begin
            if (ctrl_wr) begin
                pgm_q   <= bus_wdata[B_PGM];
                cfg_q   <= bus_wdata[B_CFG];
                erase_q <= bus_wdata[B_ERASE];
                err_q   <= bus_wdata[B_ERR];
                wen_q   <= bus_wdata[B_WEN];
            end
            rgo_q <= start_rd;
        end
    end

    // Address register: bus-loaded unless locked; cleared by a core reset.
    always_ff @(posedge clk) begin
        if (!rst_n || core_rst_hit) begin
            addr_q <= '0;
        end else if (addr_wr) begin
            addr_q <= bus_wdata[ADDR_W-1:0];
        end
    end

    // Data register: array fetch has priority over a bus load.
    always_ff @(posedge clk) begin
        if (!rst_n || core_rst_hit) begin
            data_q <= '0;
        end else if (rgo_q) begin
            data_q <= cell_rd;
        end else if (data_wr) begin
            data_q <= bus_wdata;
        end
    end

    // Completion flag: hardware set beats a software clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (done) begin
            irq_q <= 1'b1;
        end else if (flag_wr && !bus_wdata[0]) begin
            irq_q <= 1'b0;
        end
    end

    assign wdone_irq = irq_q;

    // Read-back views widened to the bus.
    logic [DATA_W-1:0] ctrl_view, addr_view, flag_view;

    // Assemble the control view; bit 5 is never driven.
    always_comb begin
        ctrl_view          = '0;
        ctrl_view[B_PGM]   = pgm_q;
        ctrl_view[B_CFG]   = cfg_q;
        ctrl_view[B_ERASE] = erase_q;
        ctrl_view[B_ERR]   = err_q;
        ctrl_view[B_WEN]   = wen_q;
        ctrl_view[B_WGO]   = busy;
        ctrl_view[B_RGO]   = rgo_q;
    end

    // Zero-extend address and flag.
    always_comb begin
        addr_view              = '0;
        addr_view[ADDR_W-1:0]  = addr_q;
        flag_view              = '0;
        flag_view[0]           = irq_q;
    end

    // Register read multiplexer; the keyhole has no storage.
    always_comb begin
        case (bus_addr)
            SEL_CTRL: bus_rdata = ctrl_view;
            SEL_ADDR: bus_rdata = addr_view;
            SEL_DATA: bus_rdata = data_q;
            SEL_FLAG: bus_rdata = flag_view;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/nvm_byte_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for nvm_byte_ctrl, attached by bind below.
// Watches the internal control state against the bus and the chip inputs.
module nvm_byte_ctrl_chk
    import nvm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 core_rst_hit,
    input logic                 pwrt_active,
    input logic                 bus_we,
    input logic [REG_SEL_W-1:0] bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic                 wen_q,
    input logic                 rgo_q,
    input logic                 err_q,
    input logic                 irq_q,
    input logic                 busy,
    input logic                 done,
    input logic                 armed,
    input logic [ADDR_W-1:0]    addr_q,
    input logic [DATA_W-1:0]    data_q
);
    // R4
    start_needs_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(armed));

    // R5
    start_needs_prior_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wen_q));

    // R10
    start_blocked_by_pwrt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(pwrt_active));

    // R2
    read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rgo_q |=> !rgo_q);

    // R6
    done_raises_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (irq_q && !busy));

    // R7
    flag_clear_by_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_q) |-> $past(bus_we && bus_addr == SEL_FLAG && !bus_wdata[0]));

    // R8
    regs_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(addr_q) && $stable(data_q)));

    // R9
    abort_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst_hit && busy) |=> (err_q && !busy && !wen_q));
endmodule

bind nvm_byte_ctrl nvm_byte_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_rst_hit (core_rst_hit),
    .pwrt_active  (pwrt_active),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .wen_q        (wen_q),
    .rgo_q        (rgo_q),
    .err_q        (err_q),
    .irq_q        (irq_q),
    .busy         (busy),
    .done         (done),
    .armed        (armed),
    .addr_q       (addr_q),
    .data_q       (data_q)
);

// File: tb/tb_nvm_byte_ctrl.sv
`timescale 1ns/1ps
module tb_nvm_byte_ctrl;
    localparam int WCYC = 12;
    localparam logic [2:0] A_CTRL = 3'd0, A_ADDR = 3'd1, A_DATA = 3'd2,
                           A_KEY = 3'd3, A_FLAG = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       core_rst_hit = 1'b0;
    logic       pwrt_active = 1'b0;
    logic       wdone_irq;

    int n_chk = 0;
    int n_bad = 0;

    nvm_byte_ctrl #(.ADDR_W(8), .DATA_W(8), .WRITE_CYCLES(WCYC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_rst_hit(core_rst_hit),
        .pwrt_active(pwrt_active), .wdone_irq(wdone_irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.1;
        d = bus_rdata;
    endtask

    task automatic mem_read(input logic [7:0] a, output logic [7:0] d);
        bus_wr(A_ADDR, a);
        bus_wr(A_CTRL, 8'h01);
        @(negedge clk);
        peek(A_DATA, d);
    endtask

    task automatic arm_and_go(input logic [7:0] go);
        bus_wr(A_KEY, 8'h55);
        bus_wr(A_KEY, 8'hAA);
        bus_wr(A_CTRL, go);
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            peek(A_CTRL, v);
            if (!v[1]) break;
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        peek(A_CTRL, v); chk("R1 ctrl", v, 8'h00);
        peek(A_ADDR, v); chk("R1 addr", v, 8'h00);
        peek(A_DATA, v); chk("R1 data", v, 8'h00);
        peek(A_KEY,  v); chk("R1 key", v, 8'h00);
        peek(A_FLAG, v); chk("R1 flag", v, 8'h00);
        bus_wr(A_CTRL, 8'h20);
        peek(A_CTRL, v); chk("R1 bit5", v, 8'h00);
    endtask

    task automatic t_write_basic();
        logic [7:0] v;
        bus_wr(A_ADDR, 8'h10);
        bus_wr(A_DATA, 8'hA5);
        bus_wr(A_CTRL, 8'h04);
        arm_and_go(8'h06);
        peek(A_CTRL, v); chk("R6 busy first", v, 8'h06);
        repeat (WCYC - 1) @(negedge clk);
        peek(A_CTRL, v); chk("R6 busy last", v, 8'h06);
        chk("R6 flag early", {7'd0, wdone_irq}, 8'h00);
        @(negedge clk);
        peek(A_CTRL, v); chk("R6 done ctrl", v, 8'h04);
        chk("R6 flag", {7'd0, wdone_irq}, 8'h01);
        mem_read(8'h10, v); chk("R6 stored", v, 8'hA5);
        bus_wr(A_FLAG, 8'h00);
    endtask

    task automatic t_read();
        logic [7:0] v;
        bus_wr(A_ADDR, 8'h11);
        bus_wr(A_DATA, 8'h5A);
        bus_wr(A_CTRL, 8'h04);
        arm_and_go(8'h06);
        wait_idle();
        bus_wr(A_FLAG, 8'h00);
        bus_wr(A_DATA, 8'hEE);
        bus_wr(A_CTRL, 8'h01);
        peek(A_DATA, v); chk("R2 before fetch", v, 8'hEE);
        peek(A_CTRL, v); chk("R2 bit0 set", v, 8'h01);
        @(negedge clk);
        peek(A_DATA, v); chk("R2 fetched", v, 8'h5A);
        peek(A_CTRL, v); chk("R2 bit0 clear", v, 8'h00);
        bus_wr(A_DATA, 8'h77);
        bus_wr(A_CTRL, 8'h81);
        repeat (2) @(negedge clk);
        peek(A_DATA, v); chk("R3 data kept", v, 8'h77);
        peek(A_CTRL, v); chk("R3 no read", v, 8'h80);
        bus_wr(A_CTRL, 8'h00);
    endtask

    task automatic t_same_write();
        logic [7:0] v;
        bus_wr(A_ADDR, 8'h10);
        bus_wr(A_DATA, 8'h11);
        arm_and_go(8'h06);
        peek(A_CTRL, v); chk("R5 no start", v, 8'h04);
        repeat (WCYC + 2) @(negedge clk);
        chk("R5 no flag", {7'd0, wdone_irq}, 8'h00);
        mem_read(8'h10, v); chk("R5 array kept", v, 8'hA5);
    endtask

    task automatic t_bad_unlock();
        logic [7:0] v;
        bus_wr(A_ADDR, 8'h10);
        bus_wr(A_DATA, 8'h22);
        bus_wr(A_CTRL, 8'h04);
        bus_wr(A_KEY, 8'h55);
        bus_wr(A_KEY, 8'h55);
        bus_wr(A_KEY, 8'hAA);
        peek(A_KEY, v); chk("R4 key reads 0", v, 8'h00);
        bus_wr(A_CTRL, 8'h06);
        peek(A_CTRL, v); chk("R4 repeated 55", v, 8'h04);
        bus_wr(A_KEY, 8'h55);
        bus_wr(A_ADDR, 8'h10);
        bus_wr(A_KEY, 8'hAA);
        bus_wr(A_CTRL, 8'h06);
        peek(A_CTRL, v); chk("R4 split keys", v, 8'h04);
        bus_wr(A_KEY, 8'h55);
        bus_wr(A_KEY, 8'hAA);
        bus_wr(A_DATA, 8'h22);
        bus_wr(A_CTRL, 8'h06);
        peek(A_CTRL, v); chk("R4 late start", v, 8'h04);
        repeat (WCYC + 2) @(negedge clk);
        mem_read(8'h10, v); chk("R4 array kept", v, 8'hA5);
    endtask

    task automatic t_pwrt();
        logic [7:0] v;
        pwrt_active = 1'b1;
        bus_wr(A_ADDR, 8'h10);
        bus_wr(A_DATA, 8'h33);
        bus_wr(A_CTRL, 8'h04);
        arm_and_go(8'h06);
        peek(A_CTRL, v); chk("R10 no start", v, 8'h04);
        pwrt_active = 1'b0;
        repeat (WCYC + 2) @(negedge clk);
        mem_read(8'h10, v); chk("R10 array kept", v, 8'hA5);
    endtask

    task automatic t_lock();
        logic [7:0] v;
        bus_wr(A_ADDR, 8'h20);
        bus_wr(A_DATA, 8'h3C);
        bus_wr(A_CTRL, 8'h04);
        arm_and_go(8'h06);
        bus_wr(A_ADDR, 8'h21);
        bus_wr(A_DATA, 8'h00);
        bus_wr(A_CTRL, 8'h00);
        peek(A_ADDR, v); chk("R8 addr locked", v, 8'h20);
        peek(A_DATA, v); chk("R8 data locked", v, 8'h3C);
        peek(A_CTRL, v); chk("R8 ctrl locked", v, 8'h06);
        wait_idle();
        mem_read(8'h20, v); chk("R8 stored", v, 8'h3C);
        bus_wr(A_FLAG, 8'h00);
    endtask

    task automatic t_flag_race();
        logic [7:0] v;
        bus_wr(A_ADDR, 8'h30);
        bus_wr(A_DATA, 8'h99);
        bus_wr(A_CTRL, 8'h04);
        arm_and_go(8'h06);
        repeat (WCYC - 1) @(negedge clk);
        bus_we = 1'b1; bus_addr = A_FLAG; bus_wdata = 8'h00;
        @(negedge clk);
        bus_we = 1'b0;
        chk("R7 set beats clear", {7'd0, wdone_irq}, 8'h01);
        bus_wr(A_FLAG, 8'h01);
        chk("R7 write 1 no effect", {7'd0, wdone_irq}, 8'h01);
        bus_wr(A_FLAG, 8'h00);
        peek(A_FLAG, v); chk("R7 cleared", v, 8'h00);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        bus_wr(A_ADDR, 8'h30);
        bus_wr(A_DATA, 8'h66);
        bus_wr(A_CTRL, 8'h54);
        arm_and_go(8'h56);
        repeat (3) @(negedge clk);
        core_rst_hit = 1'b1;
        @(negedge clk);
        core_rst_hit = 1'b0;
        peek(A_CTRL, v); chk("R9 ctrl", v, 8'h58);
        peek(A_ADDR, v); chk("R9 addr", v, 8'h00);
        peek(A_DATA, v); chk("R9 data", v, 8'h00);
        repeat (WCYC + 2) @(negedge clk);
        chk("R9 no flag", {7'd0, wdone_irq}, 8'h00);
        peek(A_CTRL, v); chk("R9 stays idle", v, 8'h58);
        bus_wr(A_CTRL, 8'h00);
        mem_read(8'h30, v); chk("R9 array kept", v, 8'h99);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_basic();
        t_read();
        t_same_write();
        t_bad_unlock();
        t_pwrt();
        t_lock();
        t_flag_race();
        t_abort();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule